// File: doc/BRIEF.md
# Triple Buffer Frame Repeat Controller

This block manages the ownership of three frame stores in external memory that sit between a video producer running at a low frame rate and a display consumer that must keep a fixed, higher frame rate. It hands the producer (writer) a buffer that nobody reads. It hands the consumer (reader) the oldest completed frame that it has not yet shown. When the consumer starts an output frame and no new frame is waiting, it shows its current buffer again. This is how the slow stream is brought up to the faster output rate.

No completed frame is ever overwritten or skipped. When the writer finishes a frame while another completed frame is still waiting, there is no free buffer left. The writer is then told to stall until the reader picks up the waiting frame. The block only sees frame-level pulses and produces only buffer base addresses and the stall flag. The pixel path and the memory masters live elsewhere.

The three buffers are laid out back to back from a base address. With the default parameters the base is 0x10000000 and each frame is 1024 x 768 pixels at 3 bytes per pixel, so 0x240000 bytes. The three buffers therefore start at 0x10000000, 0x10240000 and 0x10480000.

Top module: `triple_buf_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, the reader address is buffer 0 (0x10000000), the writer address is buffer 1 (0x10240000), `wr_stall` is 0 and no frame is waiting.
- R2: Buffer n starts at BASE_ADDR + n x (H_PIXELS x V_LINES x BYTES_PER_PIXEL), for n in 0..2. Both address outputs always carry one of these three values.
- R3: The writer and reader buffers always differ. A waiting frame never sits in the buffer being read or written.
- R4: A `wr_frame_done` pulse with no frame waiting turns the finished buffer into the waiting frame. The writer moves to the third buffer (neither the read buffer nor its old buffer) on the next cycle, with no stall.
- R5: An accepted `rd_frame_start` with no frame waiting leaves `rd_base` unchanged, so the frame repeats.
- R6: An accepted `rd_frame_start` with a frame waiting moves `rd_base` to that waiting frame on the next cycle.
- R7: A `wr_frame_done` pulse while a frame is already waiting raises `wr_stall` on the next cycle and leaves `wr_base` unchanged.
- R8: While `wr_stall` is high, `wr_frame_done` is ignored. The next accepted `rd_frame_start` gives the reader the older waiting frame, makes the writer's finished frame the waiting one, hands the writer the buffer the reader released, and drops `wr_stall`. The reader therefore sees every frame once, in completion order.
- R9: When `rd_frame_start` is accepted in the same cycle as `wr_frame_done` with a frame waiting and no stall, the reader takes the waiting frame. The writer's frame becomes waiting, the writer moves to the released buffer, and no stall occurs.
- R10: After an accepted `rd_frame_start`, further `rd_frame_start` pulses are ignored until `rd_frame_done`. A start arriving in the same cycle as `rd_frame_done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pulses are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_frame_done | input | 1 | One-cycle pulse: writer finished its current frame |
| rd_frame_start | input | 1 | One-cycle pulse: reader begins an output frame |
| rd_frame_done | input | 1 | One-cycle pulse: reader finished its output frame |
| wr_base | output | ADDR_W | Base address of the buffer the writer fills |
| rd_base | output | ADDR_W | Base address of the buffer the reader scans |
| wr_stall | output | 1 | Writer must hold off: no free buffer for its next frame |

## Verification
Directed sequences walk the block through each ownership case in turn. These are a repeat with nothing waiting, a hand-over to a waiting frame, a finish that causes a stall, a finish ignored while stalled, and a reader start coinciding with a writer finish. Each case has a different expected address pair, so a mix-up between the cases shows up as a wrong address. A redundant start inside an active read frame and a start coinciding with frame-done separate the reader gating from the buffer logic. A long random run with independent pulse rates compares both addresses and the stall flag against a reference model every cycle. It also tags each completed frame with a sequence number and requires that the reader only ever advances by exactly one number, which exposes any dropped or reordered frame.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
   localparam int NBUF = 3;
   localparam int IDX_W = 2;

   typedef logic [IDX_W-1:0] bidx_t;

   // Index of the buffer that is neither a nor b (a != b, both < 3).
   function automatic bidx_t tbuf_other(input bidx_t a, input bidx_t b);
      return bidx_t'(2'd3 - a - b);
   endfunction
endpackage

// File: rtl/tbuf_addr_map.sv
module tbuf_addr_map
   import tbuf_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h1000_0000,
   parameter int unsigned       FRAME_BYTES = 32'h0024_0000
) (
   input  bidx_t             idx,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] slot_base [NBUF];

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      assign slot_base[g] = BASE_ADDR + ADDR_W'(longint'(g) * longint'(FRAME_BYTES));
   end

   always_comb begin
      addr = slot_base[0];
      for (int k = 1; k < NBUF; k++) begin
         if (idx == bidx_t'(k)) addr = slot_base[k];
      end
   end
endmodule

// File: rtl/tbuf_read_track.sv
module tbuf_read_track (
   input  logic clk,
   input  logic rst,
   input  logic rd_start,
   input  logic rd_done,
   output logic take,
   output logic active
);
   always_comb take = rd_start && (!active || rd_done);

   always_ff @(posedge clk) begin
      if (rst)          active <= 1'b0;
      else if (take)    active <= 1'b1;
      else if (rd_done) active <= 1'b0;
   end

   // R10: a frame-done without a new start leaves the reader idle
   a_r10_done_clears: assert property (@(posedge clk) disable iff (rst)
      (rd_done && !rd_start) |=> !active);
   // R10: an accepted start leaves the reader busy
   a_r10_start_marks_busy: assert property (@(posedge clk) disable iff (rst)
      take |=> active);
endmodule

// File: rtl/tbuf_rotator.sv
module tbuf_rotator
   import tbuf_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  take,
   input  logic  wr_done,
   output bidx_t rd_idx,
   output bidx_t wr_idx,
   output logic  stall
);
   bidx_t rd_q, wr_q, pend_q;
   logic  pv_q, stall_q;
   bidx_t rd_n, wr_n, pend_n;
   logic  pv_n, stall_n;

   always_comb begin
      rd_n    = rd_q;
      wr_n    = wr_q;
      pend_n  = pend_q;
      pv_n    = pv_q;
      stall_n = stall_q;
      if (stall_q) begin
         // writer holds a finished frame, another one waits ahead of it
         if (take) begin
            rd_n    = pend_q;
            pend_n  = wr_q;
            wr_n    = rd_q;
            pv_n    = 1'b1;
            stall_n = 1'b0;
         end
      end else if (pv_q) begin
         unique case ({take, wr_done})
            2'b10: begin
               rd_n = pend_q;
               pv_n = 1'b0;
            end
            2'b01: stall_n = 1'b1;
            2'b11: begin
               rd_n   = pend_q;
               pend_n = wr_q;
               wr_n   = rd_q;
               pv_n   = 1'b1;
            end
            default: ;
         endcase
      end else if (wr_done) begin
         pend_n = wr_q;
         wr_n   = tbuf_other(rd_q, wr_q);
         pv_n   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q    <= bidx_t'(0);
         wr_q    <= bidx_t'(1);
         pend_q  <= bidx_t'(2);
         pv_q    <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         rd_q    <= rd_n;
         wr_q    <= wr_n;
         pend_q  <= pend_n;
         pv_q    <= pv_n;
         stall_q <= stall_n;
      end
   end

   assign rd_idx = rd_q;
   assign wr_idx = wr_q;
   assign stall  = stall_q;

   // R3: ownership stays disjoint
   a_r3_distinct: assert property (@(posedge clk) disable iff (rst)
      (rd_q != wr_q) && (!pv_q || (pend_q != rd_q && pend_q != wr_q)));
   // R7: a stall only exists with a waiting frame
   a_r7_stall_has_waiting: assert property (@(posedge clk) disable iff (rst)
      stall_q |-> pv_q);
   // R7: finish on top of a waiting frame stalls the writer in place
   a_r7_stall_rise: assert property (@(posedge clk) disable iff (rst)
      (pv_q && !stall_q && wr_done && !take) |=> (stall_q && $stable(wr_q)));
   // R8: writer keeps its buffer while stalled and unserved
   a_r8_hold_writer: assert property (@(posedge clk) disable iff (rst)
      (stall_q && !take) |=> $stable(wr_q) && stall_q);
   // R4: finish with nothing waiting moves writer to the third buffer
   a_r4_move_writer: assert property (@(posedge clk) disable iff (rst)
      (!pv_q && wr_done) |=> (wr_q != $past(wr_q) && wr_q != $past(rd_q) && !stall_q));
   // R5: start with nothing waiting repeats
   a_r5_repeat: assert property (@(posedge clk) disable iff (rst)
      (!pv_q && take) |=> rd_q == $past(rd_q));
   // R6: start with a frame waiting takes it
   a_r6_take_waiting: assert property (@(posedge clk) disable iff (rst)
      (pv_q && take) |=> rd_q == $past(pend_q));
endmodule

// File: rtl/triple_buf_ctrl.sv
module triple_buf_ctrl
   import tbuf_pkg::*;
#(
   parameter int                ADDR_W          = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR       = 32'h1000_0000,
   parameter int                H_PIXELS        = 1024,
   parameter int                V_LINES         = 768,
   parameter int                BYTES_PER_PIXEL = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_frame_done,
   input  logic              rd_frame_start,
   input  logic              rd_frame_done,
   output logic [ADDR_W-1:0] wr_base,
   output logic [ADDR_W-1:0] rd_base,
   output logic              wr_stall
);
   localparam int unsigned FRAME_BYTES = H_PIXELS * V_LINES * BYTES_PER_PIXEL;
   localparam longint unsigned REGION_END =
      longint'(BASE_ADDR) + longint'(NBUF) * longint'(FRAME_BYTES);
   localparam logic [ADDR_W-1:0] TOP_SLOT =
      BASE_ADDR + ADDR_W'(longint'(NBUF - 1) * longint'(FRAME_BYTES));

   initial begin : p_cfg_check
      a_cfg_dims: assert (H_PIXELS > 0 && V_LINES > 0 && BYTES_PER_PIXEL > 0)
         else $fatal(1, "frame dimensions must be positive");
      a_cfg_fit: assert (ADDR_W >= 8 && ADDR_W <= 48 &&
                         REGION_END <= (64'd1 << ADDR_W))
         else $fatal(1, "buffer region does not fit the address width");
   end

   logic  take, rd_active;
   bidx_t rd_idx, wr_idx;

   tbuf_read_track u_track (
      .clk      (clk),
      .rst      (rst),
      .rd_start (rd_frame_start),
      .rd_done  (rd_frame_done),
      .take     (take),
      .active   (rd_active)
   );

   tbuf_rotator u_rot (
      .clk     (clk),
      .rst     (rst),
      .take    (take),
      .wr_done (wr_frame_done),
      .rd_idx  (rd_idx),
      .wr_idx  (wr_idx),
      .stall   (wr_stall)
   );

   tbuf_addr_map #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .FRAME_BYTES(FRAME_BYTES))
   u_wr_map (.idx(wr_idx), .addr(wr_base));

   tbuf_addr_map #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .FRAME_BYTES(FRAME_BYTES))
   u_rd_map (.idx(rd_idx), .addr(rd_base));

   // R1: reset lands on the fixed starting assignment
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (rd_base == BASE_ADDR &&
               wr_base == BASE_ADDR + ADDR_W'(FRAME_BYTES) && !wr_stall));
   // R2: addresses lie on a buffer boundary inside the region
   a_r2_rd_slot: assert property (@(posedge clk) disable iff (rst)
      rd_base >= BASE_ADDR && rd_base <= TOP_SLOT &&
      ((rd_base - BASE_ADDR) % ADDR_W'(FRAME_BYTES)) == '0);
   a_r2_wr_slot: assert property (@(posedge clk) disable iff (rst)
      wr_base >= BASE_ADDR && wr_base <= TOP_SLOT &&
      ((wr_base - BASE_ADDR) % ADDR_W'(FRAME_BYTES)) == '0);
   // R3: at the ports the two addresses never coincide
   a_r3_ports_differ: assert property (@(posedge clk) disable iff (rst)
      wr_base != rd_base);
   // R10: a repeated start inside an active read frame changes nothing
   a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
      (rd_active && rd_frame_start && !rd_frame_done) |=> $stable(rd_base));
endmodule

// File: tb/triple_buf_ctrl_tb_top.sv
module triple_buf_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_frame_done = 1'b0;
   logic        rd_frame_start = 1'b0;
   logic        rd_frame_done = 1'b0;
   logic [31:0] wr_base, rd_base;
   logic        wr_stall;

   int tests = 0;
   int fails = 0;
   bit summary_done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   triple_buf_ctrl dut_i (
      .clk(clk), .rst(rst),
      .wr_frame_done(wr_frame_done),
      .rd_frame_start(rd_frame_start),
      .rd_frame_done(rd_frame_done),
      .wr_base(wr_base), .rd_base(rd_base), .wr_stall(wr_stall)
   );

   // R2: buffer n at 0x10000000 + n * (1024*768*3)
   function automatic logic [31:0] slot_addr(input int n);
      return 32'h1000_0000 + 32'(n) * 32'(1024 * 768 * 3);
   endfunction

   // reference state built from the requirements
   int m_rd, m_wr, m_pend;
   bit m_pv, m_stall, m_act;
   int frame_id [3];
   int next_id, shown_id;

   task automatic model_reset();
      m_rd = 0; m_wr = 1; m_pend = 2;
      m_pv = 0; m_stall = 0; m_act = 0;
      frame_id[0] = 0; frame_id[1] = -1; frame_id[2] = -1;
      next_id = 1; shown_id = 0;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic model_step(input bit wd, input bit rs, input bit rdn);
      bit take;
      int old_rd;
      take = rs && (!m_act || rdn);
      old_rd = m_rd;
      if (take) m_act = 1; else if (rdn) m_act = 0;
      if (m_stall) begin
         if (take) begin
            m_rd = m_pend; m_pend = m_wr; m_wr = old_rd; m_stall = 0; m_pv = 1;
         end
      end else if (m_pv) begin
         if (take && wd) begin
            frame_id[m_wr] = next_id++;
            m_rd = m_pend; m_pend = m_wr; m_wr = old_rd;
         end else if (take) begin
            m_rd = m_pend; m_pv = 0;
         end else if (wd) begin
            frame_id[m_wr] = next_id++;
            m_stall = 1;
         end
      end else if (wd) begin
         frame_id[m_wr] = next_id++;
         m_pend = m_wr; m_wr = 3 - m_rd - m_wr; m_pv = 1;
      end
      // R8: the reader may only advance to the very next completed frame
      if (m_rd != old_rd) begin
         check(frame_id[m_rd] == shown_id + 1, "R8", "frame order",
               32'(frame_id[m_rd]), 32'(shown_id + 1));
         shown_id = frame_id[m_rd];
      end
   endtask

   // called at a falling edge; returns just after the next falling edge
   task automatic step(input bit wd, input bit rs, input bit rdn);
      wr_frame_done = wd; rd_frame_start = rs; rd_frame_done = rdn;
      @(posedge clk);
      model_step(wd, rs, rdn);
      @(negedge clk);
      wr_frame_done = 0; rd_frame_start = 0; rd_frame_done = 0;
   endtask

   task automatic expect_state(input string req, input int rdi, input int wri, input bit st);
      check(rd_base == slot_addr(rdi), req, "rd_base", rd_base, slot_addr(rdi));
      check(wr_base == slot_addr(wri), req, "wr_base", wr_base, slot_addr(wri));
      check(wr_stall == st, req, "wr_stall", 32'(wr_stall), 32'(st));
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin : p_watchdog
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : p_main
      model_reset();
      repeat (3) @(negedge clk);
      // R1: during reset
      expect_state("R1", 0, 1, 0);
      rst = 0;
      @(negedge clk);
      expect_state("R1", 0, 1, 0);
      check(wr_base == 32'h1024_0000, "R2", "buffer 1 address", wr_base, 32'h1024_0000);

      // R5: start with nothing waiting repeats buffer 0
      step(0, 1, 0); expect_state("R5", 0, 1, 0);
      step(0, 0, 1);
      // R4: finish moves writer to buffer 2
      step(1, 0, 0); expect_state("R4", 0, 2, 0);
      check(wr_base == 32'h1048_0000, "R2", "buffer 2 address", wr_base, 32'h1048_0000);
      // R6: start takes waiting buffer 1
      step(0, 1, 0); expect_state("R6", 1, 2, 0);
      // R4: writer finishes buffer 2, moves to buffer 0
      step(1, 0, 0); expect_state("R4", 1, 0, 0);
      // R10: extra start while reading is ignored though a frame waits
      step(0, 1, 0); expect_state("R10", 1, 0, 0);
      step(0, 0, 1);
      // R7: finish while frame 2 waits stalls writer on buffer 0
      step(1, 0, 0); expect_state("R7", 1, 0, 1);
      // R8: finish while stalled is ignored
      step(1, 0, 0); expect_state("R8", 1, 0, 1);
      // R8: next start: reader gets 2, writer gets released 1, stall drops
      step(0, 1, 0); expect_state("R8", 2, 1, 0);
      // R10: start together with done is accepted, takes waiting 0
      step(0, 1, 1); expect_state("R10", 0, 1, 0);
      step(0, 0, 1);
      // R9: set up a waiting frame, then coincide start and finish
      step(1, 0, 0); expect_state("R4", 0, 2, 0);
      step(1, 1, 0); expect_state("R9", 1, 0, 0);
      step(0, 0, 1);
      expect_state("R3", m_rd, m_wr, m_stall);

      // random phase, fixed seed
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4000; i++) begin
         bit wd, rs, rdn;
         wd  = ($urandom % 23) == 0;
         rs  = ($urandom % 9) == 0;
         rdn = ($urandom % 6) == 0;
         step(wd, rs, rdn);
         // R3/R5/R6/R7/R9 compared against the reference every cycle
         check(rd_base == slot_addr(m_rd), "R6", "random rd_base", rd_base, slot_addr(m_rd));
         check(wr_base == slot_addr(m_wr), "R4", "random wr_base", wr_base, slot_addr(m_wr));
         check(wr_stall == m_stall, "R7", "random wr_stall", 32'(wr_stall), 32'(m_stall));
         check(wr_base != rd_base, "R3", "addresses differ", wr_base, rd_base);
      end

      // R1: reset mid-run restores the start state
      rst = 1;
      @(negedge clk);
      rst = 0;
      model_reset();
      @(negedge clk);
      expect_state("R1", 0, 1, 0);
      finish_run();
   end
endmodule